// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel Bank

A bank of pulse-width-modulated outputs, each driven by its own N-bit phase accumulator. On every clock an enabled channel adds its frequency increment to the accumulator. One wrap of the accumulator is one output cycle, so the output frequency is increment × clock / 2^N. The output is high for the part of each cycle in which the upper eight accumulator bits reach an inverted on-time setting.

Each channel has one 32-bit control word on a simple write-strobe / combinational-read register bus, and channels sit at a fixed 1 KiB address stride. Software writes a new increment and on-time setting into shadow fields, then sets a self-clearing update request. The hardware copies the shadow fields into the running fields at the next accumulator wrap and clears the request in the same cycle. While a request is pending, new increment and on-time values are dropped, so a late write cannot disturb the running waveform. The enable bit always takes effect at once.

Top module: `pwm_phase_bank`

## Requirements
- R1: Control word layout: bit 31 enable, bit 30 update request, bits [8+N-1:8] frequency increment, bits [7:0] inverted on-time; other bits read 0. Channel k sits at byte address k×0x400 and decodes only at offset 0. A read returns the shadow increment and on-time with the live enable and request bits. A read of an absent channel returns 0, and writes to absent channels or non-zero offsets change nothing.
- R2: After reset every channel reads enable 0, request 0, increment 1, on-time 0xFF, and every output is low.
- R3: An enabled channel's output repeats every 2^N / increment clocks (when the increment divides 2^N), one period per accumulator wrap.
- R4: An enabled output is high when the upper 8 accumulator bits are greater than or equal to the running on-time value. A value of 0xFF keeps the output low, and 0 keeps it high.
- R5: Enable takes effect on the next clock edge. While it is 0 the output is low and the accumulator is held at zero, so a newly enabled channel starts a cycle from phase zero.
- R6: Increment and on-time writes change only the shadow fields. The output keeps its running settings until an update request is committed.
- R7: A set update request reads back as 1 until the accumulator wraps. On that wrap it clears, and the shadow fields become the running ones.
- R8: While a request is pending, writes leave the shadow increment, the on-time and the request bit unchanged. The enable bit is still written.
- R9: A written increment of zero is stored as 1.
- R10: A request pending on a disabled channel commits on the next clock edge.
- R11: Channels run and are configured independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address; channel index in the bits above STRIDE_LSB |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Read data depends combinationally on the address, so a register check samples one time step after the address changes. Register values written at an edge are read in the half cycle that follows. A committed setting shows at the output within one old period of the request (2^N / old increment clocks), so output checks start only after that window. Enable and disable are checked at the first falling edge after the write edge, and a freshly enabled channel's first sixteen samples are compared bit by bit against a low-then-high pattern. Duty and period are measured over whole periods, which makes the counts independent of the starting phase.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int CTRL_EN_BIT  = 31;
  localparam int CTRL_UPD_BIT = 30;
  localparam int INC_LSB      = 8;
  localparam int DUTY_W       = 8;

  // Output level for one phase sample: inverted on-time 0xFF means never high.
  function automatic logic duty_high(input logic [DUTY_W-1:0] phase_top,
                                     input logic [DUTY_W-1:0] duty_inv);
    return (duty_inv != {DUTY_W{1'b1}}) && (phase_top >= duty_inv);
  endfunction
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec #(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 10,
  localparam int IDX_W     = ADDR_W - STRIDE_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CH-1:0] wr_sel,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  assign idx = addr[ADDR_W-1:STRIDE_LSB];
  assign hit = (addr[STRIDE_LSB-1:0] == '0) && (int'(idx) < NUM_CH);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_sel[i] = wr && hit && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/pwm_phase_chan.sv
module pwm_phase_chan
  import pwm_phase_pkg::*;
#(
  parameter int INC_W  = 22,
  localparam int CFG_W = INC_W + DUTY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word,
  output logic             pwm_out,
  output logic             wrap,
  output logic             commit,
  output logic             upd,
  output logic             en,
  output logic [CFG_W-1:0] cfg
);
  logic [INC_W-1:0]  acc, act_inc, sh_inc;
  logic [DUTY_W-1:0] act_duty, sh_duty;
  logic [INC_W:0]    sum;

  function automatic logic [INC_W-1:0] legal_inc(input logic [INC_W-1:0] v);
    return (v == '0) ? INC_W'(1) : v;
  endfunction

  assign sum    = {1'b0, acc} + {1'b0, act_inc};
  assign wrap   = en && sum[INC_W];
  assign commit = upd && (wrap || !en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      upd      <= 1'b0;
      acc      <= '0;
      sh_inc   <= INC_W'(1);
      act_inc  <= INC_W'(1);
      sh_duty  <= '1;
      act_duty <= '1;
    end else begin
      acc <= en ? sum[INC_W-1:0] : '0;
      if (upd) begin
        if (commit) begin
          act_inc  <= sh_inc;
          act_duty <= sh_duty;
          upd      <= 1'b0;
        end
      end else if (wr_en) begin
        sh_inc  <= legal_inc(wdata[INC_LSB +: INC_W]);
        sh_duty <= wdata[DUTY_W-1:0];
        upd     <= wdata[CTRL_UPD_BIT];
      end
      if (wr_en) en <= wdata[CTRL_EN_BIT];
    end
  end

  assign pwm_out = en && duty_high(acc[INC_W-1 -: DUTY_W], act_duty);
  assign cfg     = {sh_inc, sh_duty};

  always_comb begin
    rd_word                  = '0;
    rd_word[CTRL_EN_BIT]     = en;
    rd_word[CTRL_UPD_BIT]    = upd;
    rd_word[INC_LSB +: INC_W] = sh_inc;
    rd_word[DUTY_W-1:0]      = sh_duty;
  end
endmodule

// File: rtl/pwm_phase_bank.sv
module pwm_phase_bank
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int INC_W      = 22,
  parameter int ADDR_W     = 12,
  parameter int STRIDE_LSB = 10,
  localparam int IDX_W     = ADDR_W - STRIDE_LSB,
  localparam int CFG_W     = INC_W + DUTY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]            wr_sel;
  logic                         rd_hit;
  logic [IDX_W-1:0]             rd_idx;
  logic [NUM_CH-1:0][31:0]      chan_rd;
  logic [NUM_CH-1:0]            wrap_vec, commit_vec, upd_vec, en_vec;
  logic [NUM_CH-1:0][CFG_W-1:0] cfg_vec;

  pwm_addr_dec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STRIDE_LSB(STRIDE_LSB)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wr_sel(wr_sel), .hit(rd_hit), .idx(rd_idx)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_phase_chan #(.INC_W(INC_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[g]), .wdata(bus_wdata),
      .rd_word(chan_rd[g]), .pwm_out(pwm_out[g]), .wrap(wrap_vec[g]),
      .commit(commit_vec[g]), .upd(upd_vec[g]), .en(en_vec[g]), .cfg(cfg_vec[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_hit && (rd_idx == IDX_W'(i))) bus_rdata = chan_rd[i];
    end
  end
endmodule

// File: rtl/pwm_phase_bank_chk.sv
module pwm_phase_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int INC_W  = 22,
  localparam int CFG_W = INC_W + 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            wrap_vec,
  input logic [NUM_CH-1:0]            commit_vec,
  input logic [NUM_CH-1:0]            upd_vec,
  input logic [NUM_CH-1:0]            en_vec,
  input logic [NUM_CH-1:0][CFG_W-1:0] cfg_vec
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[g] |-> !pwm_out[g]);
    p_clear_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_vec[g]) |-> $past(wrap_vec[g] || !en_vec[g]));
    p_pending_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vec[g] |=> $stable(cfg_vec[g]));
    p_inc_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vec[g][CFG_W-1:8] != '0);
    p_idle_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_vec[g] && !en_vec[g]) |=> !upd_vec[g]);
    p_commit_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vec[g] |=> !upd_vec[g]);
  end
endmodule

bind pwm_phase_bank pwm_phase_bank_chk #(.NUM_CH(NUM_CH), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .wrap_vec(wrap_vec),
  .commit_vec(commit_vec), .upd_vec(upd_vec), .en_vec(en_vec), .cfg_vec(cfg_vec)
);

// File: tb/pwm_phase_bank_tb.sv
module pwm_phase_bank_tb;
  localparam int NCH = 2;
  localparam int IW  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t exp_q[$];
  item_t act_q[$];

  always #4 clk = ~clk;

  pwm_phase_bank #(.NUM_CH(NCH), .INC_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] mk(bit en, bit upd, logic [15:0] inc, logic [7:0] duty);
    return {en, upd, 6'b0, inc, duty};
  endfunction

  // Driver side: expected and observed items enter the scoreboard in pairs.
  task automatic push(string tag, logic [31:0] e, logic [31:0] a);
    item_t ie, ia;
    ie.tag = tag; ie.v = e;
    ia.tag = tag; ia.v = a;
    exp_q.push_back(ie);
    act_q.push_back(ia);
  endtask

  // Monitor: pops and compares whatever has arrived.
  initial begin
    forever begin
      @(posedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        tests++;
        if (a.v !== e.v) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, a.v, e.v);
        end
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_end();
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(logic [11:0] a, logic [31:0] e, logic [31:0] m, string tag);
    bus_addr = a;
    #1;
    push(tag, e & m, bus_rdata & m);
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    rd_now(a, e, 32'hFFFF_FFFF, tag);
  endtask

  task automatic count_high(int ch, int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk); #1;
      hi += int'(pwm_out[ch]);
    end
  endtask

  task automatic measure_period(int ch, output int per);
    logic prev;
    int guard;
    per = -1;
    guard = 0;
    @(negedge clk); #1; prev = pwm_out[ch];
    while (!(pwm_out[ch] && !prev) && guard < 1000) begin
      prev = pwm_out[ch]; @(negedge clk); #1; guard++;
    end
    per = 0;
    prev = pwm_out[ch];
    @(negedge clk); #1; per = 1;
    while (!(pwm_out[ch] && !prev) && per < 1000) begin
      prev = pwm_out[ch]; @(negedge clk); #1; per++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hi, per;
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    rd_chk(12'h000, 32'h0000_01FF, "R2 ch0 reset word");
    rd_chk(12'h400, 32'h0000_01FF, "R2 ch1 reset word");
    push("R2 outputs low", 32'h0, {30'b0, pwm_out});

    // R9: zero increment stored as 1
    wr(12'h000, mk(0, 0, 16'h0000, 8'h80)); wr_end();
    rd_chk(12'h000, 32'h0000_0180, "R9 zero increment clamps");

    // R10: pending request on a disabled channel commits next clock
    wr(12'h000, mk(0, 1, 16'h1000, 8'h80)); wr_end();
    rd_chk(12'h000, 32'h0010_0080, "R10 idle commit clears request");

    // R5/R4: enable starts from phase zero: 8 low then 8 high
    wr(12'h000, mk(1, 0, 16'h1000, 8'h80)); wr_end();
    #1; pat[0] = pwm_out[0];
    for (int k = 1; k < 16; k++) begin
      @(negedge clk); #1; pat[k] = pwm_out[0];
    end
    push("R5 first cycle pattern", 32'h0000_FF00, {16'h0, pat});

    // R3/R4: period 16, half duty
    measure_period(0, per);
    push("R3 period inc 0x1000", 32'd16, per);
    count_high(0, 64, hi);
    push("R4 duty 0x80", 32'd32, hi);

    // R6: shadow-only write keeps running waveform
    wr(12'h000, mk(1, 0, 16'h1000, 8'h00)); wr_end();
    count_high(0, 64, hi);
    push("R6 shadow write no effect", 32'd32, hi);
    rd_chk(12'h000, 32'h8010_0000, "R1 shadow readback");

    // R7: request visible until the wrap, then cleared and committed
    wr(12'h000, mk(1, 1, 16'h1000, 8'h00)); wr_end();
    rd_now(12'h000, 32'hC010_0000, 32'hFFFF_FFFF, "R7 request pending");
    repeat (17) @(negedge clk);
    rd_chk(12'h000, 32'h8010_0000, "R7 request cleared");
    count_high(0, 64, hi);
    push("R4 duty 0 full high", 32'd64, hi);

    // R8: second write while pending is dropped
    wr(12'h000, mk(1, 1, 16'h2000, 8'hC0));
    wr(12'h000, mk(1, 0, 16'h0800, 8'h10)); wr_end();
    rd_now(12'h000, 32'h0020_00C0, 32'h00FF_FFFF, "R8 fields held while pending");
    repeat (20) @(negedge clk);
    rd_chk(12'h000, 32'h8020_00C0, "R8 final word");
    measure_period(0, per);
    push("R3 period inc 0x2000", 32'd8, per);
    count_high(0, 64, hi);
    push("R4 duty 0xC0", 32'd16, hi);

    // R5: disable is immediate
    hi = 0;
    while (hi < 100) begin
      @(negedge clk); #1;
      if (pwm_out[0]) break;
      hi++;
    end
    bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = mk(0, 0, 16'h2000, 8'hC0);
    @(negedge clk); bus_wr = 1'b0; #1;
    push("R5 low after disable edge", 32'd0, {31'b0, pwm_out[0]});
    count_high(0, 32, hi);
    push("R5 stays low while off", 32'd0, hi);

    // R11: second channel configured independently
    wr(12'h400, mk(0, 1, 16'h2000, 8'h00)); wr_end();
    wr(12'h400, mk(1, 0, 16'h2000, 8'h00)); wr_end();
    repeat (4) @(negedge clk);
    count_high(1, 64, hi);
    push("R11 ch1 full duty", 32'd64, hi);
    count_high(0, 32, hi);
    push("R11 ch0 untouched low", 32'd0, hi);
    rd_chk(12'h400, 32'h8020_0000, "R11 ch1 word");

    // R1: absent channel and bad offset
    rd_chk(12'h800, 32'h0, "R1 absent channel reads 0");
    wr(12'hC00, mk(1, 0, 16'h3000, 8'h11)); wr_end();
    wr(12'h004, mk(1, 0, 16'h3000, 8'h11)); wr_end();
    rd_chk(12'h000, 32'h0020_00C0, "R1 ch0 unchanged by stray writes");
    rd_chk(12'h400, 32'h8020_0000, "R1 ch1 unchanged by stray writes");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule